// File: doc/BRIEF.md
# Conversion Queue Sequencer with Pause and Completion Flags

This block walks a small table of conversion command words. Each word names an input channel and carries two marker bits: one asks the scan to pause after the word, the other marks the word as the final one of the queue. For each word the sequencer sends a one-cycle start pulse with the channel number to an external converter. It waits for the converter's done pulse, then stores the returned 10-bit result in a result table at the same index as the command word.

A scan is started in one of three ways, chosen by a mode input. In external-trigger mode, a trigger pulse starts the scan and also resumes it after a pause. In software single-scan mode, a go pulse runs the queue once. In software continuous mode, the queue wraps to the first word after each completion. Two sticky flags, completion and pause, report progress. Each flag drives an interrupt request gated by its own enable. Software clears a flag by reading it as 1 and then writing 0 to it.

Top module: `cq_sequencer`

## Requirements
- R1: After reset the status is idle (0), both flags are 0, both interrupt requests are 0 and no start pulse is issued while idle.
- R2: Each word issues one `conv_start` pulse of exactly one cycle with `conv_chan` equal to the word's channel. The result that comes back with `conv_done` can then be read at `res_addr` equal to the word's index.
- R3: Words are issued in index order starting at 0. After a `conv_done` on a word without a pause bit, the next start pulse is high in the cycle immediately after the clock edge that captured the done pulse.
- R4: The completion flag (`flag_rdata` bit 0) is set when the word just finished has its last marker or sits at index DEPTH-1. In single-scan and external mode the status then returns to idle (0).
- R5: In continuous mode, completion is followed at once by a new start for word 0, with the same one-cycle spacing as R3. A scan stops at its next completion once the mode is changed to single-scan.
- R6: In external mode, a word with its pause bit sets the pause flag (`flag_rdata` bit 1) once its result is stored. The status becomes paused (2) and no start is issued until `ext_trig`, which resumes with the next word.
- R7: A word carrying both the pause bit and the last marker completes the scan: both flags are set and the status becomes idle, not paused.
- R8: In software modes, a pause bit sets the pause flag but the status never becomes paused. The next start comes exactly two cycles later than under R3.
- R9: `irq_done` equals the completion flag ANDed with `ie_done`, and `irq_pause` equals the pause flag ANDed with `ie_pause`. Flags are set whatever the enables are.
- R10: A flag clears only when `flag_wr` writes 0 to its bit after a `flag_rd` has read that bit as 1. A write of 0 without that read, or a write of 1, leaves it set. Clearing also drops its interrupt request.
- R11: If a flag event occurs on the same edge as a clearing write, the flag stays set.
- R12: Triggers that do not belong to the selected mode are ignored: `sw_go` neither starts nor resumes a scan in external mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 0 external trigger, 1 software single-scan, 2 software continuous, 3 off |
| ext_trig | input | 1 | External trigger pulse |
| sw_go | input | 1 | Software start pulse |
| cmd_we | input | 1 | Command table write enable |
| cmd_addr | input | AW | Command table write index |
| cmd_wdata | input | CH_W+2 | Command word: [CH_W-1:0] channel, [CH_W] pause, [CH_W+1] last |
| res_addr | input | AW | Result table read index |
| res_rdata | output | RES_W | Result table read data |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | CH_W | Channel to convert, valid with conv_start |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | RES_W | Conversion result, valid with conv_done |
| flag_rd | input | 1 | Flag read strobe (arms clearing of bits read as 1) |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data: bit 0 completion, bit 1 pause |
| flag_rdata | output | 2 | Flags: bit 0 completion, bit 1 pause |
| ie_done | input | 1 | Completion interrupt enable |
| ie_pause | input | 1 | Pause interrupt enable |
| irq_done | output | 1 | Completion interrupt request |
| irq_pause | output | 1 | Pause interrupt request |
| status | output | 2 | 0 idle, 1 active, 2 paused |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same edge that sets the flag again. The bench arms the flag with a read, starts a one-word scan and waits for the start pulse. It then drives the zero write in the same cycle that its converter model returns the done pulse. The two-cycle self-retrigger in software modes is also easy to miss. The bench stamps every start pulse with a cycle count and compares the gaps across a paused word with those across plain words. It also watches the status for a paused value in every cycle of that scan.

// File: rtl/cq_pkg.sv
// Shared encodings for the conversion queue sequencer.
// Assumes: mode and status codes match the values documented at the top ports.
package cq_pkg;
    typedef enum logic [1:0] {
        MODE_EXT     = 2'd0,
        MODE_SW_ONCE = 2'd1,
        MODE_SW_LOOP = 2'd2,
        MODE_OFF     = 2'd3
    } scan_mode_e;

    typedef enum logic [1:0] {
        STAT_IDLE   = 2'd0,
        STAT_ACTIVE = 2'd1,
        STAT_PAUSED = 2'd2
    } queue_stat_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_PAUSED,
        SQ_RETRIG
    } seq_state_e;

    localparam int FLAG_DONE    = 0;
    localparam int FLAG_PAUSE   = 1;
    localparam int NUM_FLAGS    = 2;
    localparam int RETRIG_DELAY = 2;
endpackage

// File: rtl/cq_regfile.sv
// Small register file with one synchronous write port and one
// combinational read port. Used for both the command table and the
// result table. Assumes: DEPTH is small enough for flops.
module cq_regfile #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    // Storage: clear on reset, write one entry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Read: asynchronous lookup.
    always_comb rdata = mem_q[raddr];
endmodule

// File: rtl/cq_flag.sv
// One sticky status flag with a read-then-write-zero clear protocol and
// a gated interrupt request. Assumes: rd_i and wr_i are single-cycle
// strobes. A set on the same edge as a clear wins.
module cq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;
    logic armed_q;
    logic clr;

    // Clear qualifies only after a read that returned 1.
    always_comb clr = wr_i && !wbit_i && armed_q;

    // Arm tracking: armed by a read of 1, consumed by any write.
    always_ff @(posedge clk) begin
        if (!rst_n)                armed_q <= 1'b0;
        else if (wr_i)             armed_q <= 1'b0;
        else if (rd_i && flag_q)   armed_q <= 1'b1;
    end

    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_i | (flag_q & ~clr);
    end

    // Outputs: flag value and enabled interrupt request.
    always_comb begin
        flag_o = flag_q;
        irq_o  = flag_q & en_i;
    end
endmodule

// File: rtl/cq_ctrl.sv
// Queue control state machine. Issues one conversion per command word,
// writes results, raises completion and pause events, and handles the
// pause, external resume and software self-retrigger cases.
// Assumes: the converter returns exactly one done per start.
module cq_ctrl
    import cq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CH_W  = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int RW   = $clog2(RETRIG_DELAY + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            ext_trig,
    input  logic            sw_go,
    input  logic [CH_W-1:0] word_chan,
    input  logic            word_pause,
    input  logic            word_last,
    input  logic            conv_done,
    output logic [AW-1:0]   ptr,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            res_we,
    output logic            set_done,
    output logic            set_pause,
    output logic [1:0]      status
);
    seq_state_e    state_q, state_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic [RW-1:0] wait_q, wait_d;
    logic          trig;
    logic          sw_mode;
    logic          end_hit;
    logic          finish;

    // Trigger selection: only the source that belongs to the mode counts.
    always_comb begin
        sw_mode = (mode == MODE_SW_ONCE) || (mode == MODE_SW_LOOP);
        unique case (mode)
            MODE_EXT:                  trig = ext_trig;
            MODE_SW_ONCE, MODE_SW_LOOP: trig = sw_go;
            default:                   trig = 1'b0;
        endcase
    end

    // Word end detection: explicit last marker or final table slot.
    always_comb begin
        end_hit = word_last || (ptr_q == AW'(DEPTH - 1));
        finish  = (state_q == SQ_WAIT) && conv_done;
    end

    // Next-state logic for the scan sequence.
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        wait_d  = wait_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (trig) begin
                    state_d = SQ_ISSUE;
                    ptr_d   = '0;
                end
            end
            SQ_ISSUE: state_d = SQ_WAIT;
            SQ_WAIT: begin
                if (conv_done) begin
                    if (end_hit) begin
                        ptr_d   = '0;
                        state_d = (mode == MODE_SW_LOOP) ? SQ_ISSUE : SQ_IDLE;
                    end else begin
                        ptr_d = ptr_q + AW'(1);
                        if (!word_pause) begin
                            state_d = SQ_ISSUE;
                        end else if (sw_mode) begin
                            state_d = SQ_RETRIG;
                            wait_d  = '0;
                        end else begin
                            state_d = SQ_PAUSED;
                        end
                    end
                end
            end
            SQ_PAUSED: begin
                if (trig) state_d = SQ_ISSUE;
            end
            SQ_RETRIG: begin
                if (wait_q == RW'(RETRIG_DELAY - 1)) state_d = SQ_ISSUE;
                else                                 wait_d  = wait_q + RW'(1);
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            ptr_q   <= '0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            wait_q  <= wait_d;
        end
    end

    // Outputs: converter request, result write, flag events, status code.
    always_comb begin
        ptr        = ptr_q;
        conv_start = (state_q == SQ_ISSUE);
        conv_chan  = word_chan;
        res_we     = finish;
        set_done   = finish && end_hit;
        set_pause  = finish && word_pause;
        unique case (state_q)
            SQ_IDLE:   status = STAT_IDLE;
            SQ_PAUSED: status = STAT_PAUSED;
            default:   status = STAT_ACTIVE;
        endcase
    end
endmodule

// File: rtl/cq_sequencer.sv
// Top level of the conversion queue sequencer: command table, result
// table, control state machine and the two status flags.
// Assumes: command words are written while the queue is idle.
module cq_sequencer
    import cq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CH_W  = 4,
    parameter int RES_W = 10,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = CH_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             ext_trig,
    input  logic             sw_go,
    input  logic             cmd_we,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [CW-1:0]    cmd_wdata,
    input  logic [AW-1:0]    res_addr,
    output logic [RES_W-1:0] res_rdata,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic             flag_rd,
    input  logic             flag_wr,
    input  logic [1:0]       flag_wdata,
    output logic [1:0]       flag_rdata,
    input  logic             ie_done,
    input  logic             ie_pause,
    output logic             irq_done,
    output logic             irq_pause,
    output logic [1:0]       status
);
    logic [AW-1:0]        ptr;
    logic [CW-1:0]        word;
    logic                 res_we;
    logic                 ev_done, ev_pause;
    logic [NUM_FLAGS-1:0] ev_vec, en_vec, flag_vec, irq_vec;

    cq_regfile #(.DEPTH(DEPTH), .W(CW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .we(cmd_we), .waddr(cmd_addr),
        .wdata(cmd_wdata), .raddr(ptr), .rdata(word)
    );

    cq_regfile #(.DEPTH(DEPTH), .W(RES_W)) u_res (
        .clk(clk), .rst_n(rst_n), .we(res_we), .waddr(ptr),
        .wdata(conv_result), .raddr(res_addr), .rdata(res_rdata)
    );

    cq_ctrl #(.DEPTH(DEPTH), .CH_W(CH_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode_sel), .ext_trig(ext_trig),
        .sw_go(sw_go), .word_chan(word[CH_W-1:0]), .word_pause(word[CH_W]),
        .word_last(word[CH_W+1]), .conv_done(conv_done), .ptr(ptr),
        .conv_start(conv_start), .conv_chan(conv_chan), .res_we(res_we),
        .set_done(ev_done), .set_pause(ev_pause), .status(status)
    );

    // Flag event and enable vectors, indexed by flag number.
    always_comb begin
        ev_vec[FLAG_DONE]  = ev_done;
        ev_vec[FLAG_PAUSE] = ev_pause;
        en_vec[FLAG_DONE]  = ie_done;
        en_vec[FLAG_PAUSE] = ie_pause;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        cq_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(ev_vec[g]), .rd_i(flag_rd),
            .wr_i(flag_wr), .wbit_i(flag_wdata[g]), .en_i(en_vec[g]),
            .flag_o(flag_vec[g]), .irq_o(irq_vec[g])
        );
    end

    // Output mapping of flags and interrupt requests.
    always_comb begin
        flag_rdata = flag_vec;
        irq_done   = irq_vec[FLAG_DONE];
        irq_pause  = irq_vec[FLAG_PAUSE];
    end
endmodule

// File: rtl/cq_sequencer_chk.sv
// Property checker for cq_sequencer, attached by bind. Observes ports only.
module cq_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       conv_start,
    input logic       conv_done,
    input logic       flag_wr,
    input logic [1:0] flag_rdata,
    input logic       ie_done,
    input logic       ie_pause,
    input logic       irq_done,
    input logic       irq_pause,
    input logic [1:0] status
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'd0 |-> !conv_start);

    p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    p_done_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rdata[0]) |-> $past(conv_done));

    p_pause_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rdata[1]) |-> $past(conv_done));

    p_paused_no_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status == 2'd2 |-> !conv_start);

    p_sw_never_paused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'd2 && mode_sel != 2'd0) |=> status != 2'd2);

    p_irq_done_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> ie_done);

    p_irq_pause_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pause |-> ie_pause);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata[0] && !flag_wr) |=> flag_rdata[0]);

    p_pause_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rdata[1] && !flag_wr) |=> flag_rdata[1]);
endmodule

bind cq_sequencer cq_sequencer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .conv_start(conv_start),
    .conv_done(conv_done), .flag_wr(flag_wr), .flag_rdata(flag_rdata),
    .ie_done(ie_done), .ie_pause(ie_pause), .irq_done(irq_done),
    .irq_pause(irq_pause), .status(status)
);

// File: tb/tb_cq_sequencer.sv
module tb_cq_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int CH_W  = 4;
    localparam int RES_W = 10;
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = CH_W + 2;
    localparam int LOGN  = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_sel = 2'd3;
    logic             ext_trig = 1'b0, sw_go = 1'b0;
    logic             cmd_we = 1'b0;
    logic [AW-1:0]    cmd_addr = '0;
    logic [CW-1:0]    cmd_wdata = '0;
    logic [AW-1:0]    res_addr = '0;
    logic [RES_W-1:0] res_rdata;
    logic             conv_start;
    logic [CH_W-1:0]  conv_chan;
    logic             conv_done = 1'b0;
    logic [RES_W-1:0] conv_result = '0;
    logic             flag_rd = 1'b0, flag_wr = 1'b0;
    logic [1:0]       flag_wdata = '0;
    logic [1:0]       flag_rdata;
    logic             ie_done = 1'b0, ie_pause = 1'b0;
    logic             irq_done, irq_pause;
    logic [1:0]       status;

    int total = 0, bad = 0;
    int cyc = 0, nlog = 0;
    int log_chan [LOGN];
    int log_cyc  [LOGN];
    bit pend = 0, seen_paused = 0, finished = 0;

    cq_sequencer #(.DEPTH(DEPTH), .CH_W(CH_W), .RES_W(RES_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int res_of(int k);
        return (log_chan[k] * 41 + k * 7 + 3) % 1024;
    endfunction

    // Converter model and start-pulse logger, all on the falling edge.
    initial forever begin
        @(negedge clk);
        cyc++;
        if (status == 2'd2) seen_paused = 1;
        if (conv_start) begin
            if (nlog < LOGN) begin
                log_chan[nlog] = int'(conv_chan);
                log_cyc[nlog]  = cyc;
            end
            nlog++;
            pend = 1;
            conv_done = 1'b0;
        end else if (pend) begin
            conv_result = RES_W'(res_of(nlog - 1));
            conv_done = 1'b1;
            pend = 0;
        end else begin
            conv_done = 1'b0;
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic prog(int idx, int chan, bit pz, bit lst);
        @(negedge clk);
        cmd_we = 1'b1; cmd_addr = AW'(idx);
        cmd_wdata = {lst, pz, CH_W'(chan)};
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // Plain table: channel (3*i+1) mod 16, no markers.
    task automatic prog_plain();
        for (int i = 0; i < DEPTH; i++) prog(i, (i * 3 + 1) % 16, 1'b0, 1'b0);
    endtask

    task automatic pulse_ext();
        @(negedge clk); ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_go = 1'b1; @(negedge clk); sw_go = 1'b0;
    endtask

    task automatic rd_flags(output logic [1:0] v);
        @(negedge clk); flag_rd = 1'b1; #1 v = flag_rdata;
        @(negedge clk); flag_rd = 1'b0;
    endtask

    task automatic wr_flags(logic [1:0] d);
        @(negedge clk); flag_wr = 1'b1; flag_wdata = d;
        @(negedge clk); flag_wr = 1'b0;
    endtask

    task automatic clear_flags();
        logic [1:0] v;
        rd_flags(v);
        wr_flags(2'b00);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && status != 2'd0; i++) @(negedge clk);
    endtask

    // Check the word order, channel and stored result of a finished scan.
    task automatic check_scan(string tag, int base, int n, int first_idx);
        check({tag, " start count"}, nlog - base, n);
        for (int k = 0; k < n; k++) begin
            int idx = (first_idx + k) % DEPTH;
            check({tag, " channel order"}, log_chan[base + k], (idx * 3 + 1) % 16);
            res_addr = AW'(idx);
            #1 check({"R2 result slot ", tag}, int'(res_rdata), res_of(base + k));
        end
    endtask

    initial begin
        logic [1:0] v;
        int base;

        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1 status", int'(status), 0);
        check("R1 flags", int'(flag_rdata), 0);
        check("R1 irqs", int'({irq_done, irq_pause}), 0);
        check("R1 no start", int'(conv_start), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", int'(status), 0);

        // R2 R3 R4 R9: single scan, last marker on word 3, enables off.
        prog_plain();
        prog(3, 10, 1'b0, 1'b1);
        mode_sel = 2'd1; base = nlog;
        pulse_sw();
        wait_idle();
        check("R4 idle after single scan", int'(status), 0);
        check("R3 first gap", log_cyc[base + 1] - log_cyc[base], 2);
        check("R3 last gap", log_cyc[base + 3] - log_cyc[base + 2], 2);
        check("R4 done flag only", int'(flag_rdata), 1);
        check("R9 flag set with enable off", int'(irq_done), 0);
        ie_done = 1'b1; #1;
        check("R9 irq with enable", int'(irq_done), 1);
        check_scan("R2 R3 single", base, 4, 0);

        // R10: write 0 without read, then write 1 after read, then read + write 0.
        wr_flags(2'b00);
        check("R10 write without read", int'(flag_rdata[0]), 1);
        rd_flags(v);
        check("R10 read value", int'(v), 1);
        wr_flags(2'b01);
        check("R10 write one keeps", int'(flag_rdata[0]), 1);
        clear_flags();
        check("R10 cleared", int'(flag_rdata[0]), 0);
        check("R10 irq dropped", int'(irq_done), 0);

        // R4: no markers, external mode, completes at index DEPTH-1.
        prog_plain();
        mode_sel = 2'd0; base = nlog;
        pulse_ext();
        wait_idle();
        check("R4 full table done flag", int'(flag_rdata), 1);
        check_scan("R4 full", base, DEPTH, 0);
        clear_flags();

        // R6 R12: external pause on word 1, last on word 3.
        prog(1, 4, 1'b1, 1'b0);
        prog(3, 10, 1'b0, 1'b1);
        ie_pause = 1'b1; base = nlog;
        pulse_ext();
        for (int i = 0; i < 100 && status != 2'd2; i++) @(negedge clk);
        check("R6 status paused", int'(status), 2);
        check("R6 pause flag only", int'(flag_rdata), 2);
        check("R9 pause irq", int'(irq_pause), 1);
        check("R6 starts before pause", nlog - base, 2);
        pulse_sw();
        repeat (6) @(negedge clk);
        check("R12 sw_go ignored in external mode", nlog - base, 2);
        check("R6 R12 still paused", int'(status), 2);
        pulse_ext();
        wait_idle();
        check("R6 both flags after resume", int'(flag_rdata), 3);
        check_scan("R6 resumed", base, 4, 0);
        clear_flags();
        check("R10 irq_pause dropped", int'(irq_pause), 0);

        // R7: pause and last on the same word.
        prog_plain();
        prog(2, 7, 1'b1, 1'b1);
        base = nlog;
        pulse_ext();
        wait_idle();
        check("R7 both flags", int'(flag_rdata), 3);
        check("R7 idle not paused", int'(status), 0);
        check("R7 count", nlog - base, 3);
        clear_flags();

        // R8: software single scan with pause on word 1.
        prog_plain();
        prog(1, 4, 1'b1, 1'b0);
        prog(3, 10, 1'b0, 1'b1);
        mode_sel = 2'd1; seen_paused = 0; base = nlog;
        pulse_sw();
        wait_idle();
        check("R8 gap before pause word", log_cyc[base + 1] - log_cyc[base], 2);
        check("R8 retrigger gap", log_cyc[base + 2] - log_cyc[base + 1], 4);
        check("R8 gap after", log_cyc[base + 3] - log_cyc[base + 2], 2);
        check("R8 never paused", int'(seen_paused), 0);
        check("R8 flags", int'(flag_rdata), 3);
        check_scan("R8 sw pause", base, 4, 0);
        clear_flags();

        // R5: continuous scan over words 0..1, stopped by switching to single.
        prog_plain();
        prog(1, 4, 1'b0, 1'b1);
        mode_sel = 2'd2; base = nlog;
        pulse_sw();
        for (int i = 0; i < 200 && nlog - base < 5; i++) @(negedge clk);
        mode_sel = 2'd1;
        wait_idle();
        check("R5 even count", (nlog - base) % 2, 0);
        check("R5 wrap to word 0", log_chan[base + 2], 1);
        check("R5 word 1 again", log_chan[base + 3], 4);
        check("R5 wrap gap", log_cyc[base + 2] - log_cyc[base + 1], 2);
        check("R5 done flag", int'(flag_rdata), 1);

        // R11: clear write on the same edge as a new completion.
        rd_flags(v);
        prog(0, 5, 1'b0, 1'b1);
        base = nlog;
        pulse_sw();
        wait (nlog == base + 1);
        @(negedge clk);
        flag_wr = 1'b1; flag_wdata = 2'b00;
        @(negedge clk);
        flag_wr = 1'b0;
        #1 check("R11 set wins over clear", int'(flag_rdata[0]), 1);
        wait_idle();
        clear_flags();
        check("R11 later clear works", int'(flag_rdata), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule